// File: doc/BRIEF.md
# Best-Four Track Candidate Sorter

This block sits at the merge point of a trigger crate. Twelve upstream processors each drive a 32-line link at twice the crossing rate. On every bunch crossing, each link carries three track candidates. The block inverts the active-low lines and assembles the two half-crossing transfers of each link into one 64-bit word. It then cuts that word into three 21-bit candidates. A full ranking of all 36 candidates by their 6-bit quality follows, and the four strongest leave on four parallel output channels, best first.

The logic runs on a single clock at the transfer rate. An internal half-crossing phase starts at the low transfer after reset. Results advance once per crossing, on the cycle that takes the second transfer. A clock-enable input freezes every register, phase included, so the pipeline can be stepped one transfer at a time while debugging. A valid flag goes down the pipeline together with the data.

Top module: `cand_best4_sorter`

## Requirements
- R1: While reset is held, every output channel reads zero and `out_valid` is low.
- R2: A link line driven low carries a logic one. A crossing whose lines are all high yields no candidates, so every channel reads zero.
- R3: The first transfer of a crossing is bits 31:0 of the link word and the second is bits 63:32. Candidate slot s (0..2) occupies bits 21s+20 down to 21s. Its quality is the top 6 bits of those 21 (bits 20:15 of the candidate). Word bit 63 has no effect.
- R4: Channels 0..3 carry the four highest-quality candidates of the crossing, whole and unmodified, in non-increasing quality order.
- R5: Equal qualities are ordered by global index link*3+slot, lower first. The lower link wins first, then the lower slot.
- R6: A quality of zero is no candidate and loses to any nonzero quality. A channel left without a real candidate outputs all zeros, whatever the payload bits were.
- R7: A crossing's result and its `in_valid` (sampled with the second transfer) appear on the outputs at the second crossing boundary after the one that completes it: three crossing updates in all, counting the capture.
- R8: While `ce` is low, no register changes and the link lines are ignored. On resumption the interrupted crossing completes with a correct result.
- R9: Back-to-back crossings each produce their own result on successive crossings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer-rate clock (two cycles per crossing) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable; low freezes all state |
| in_valid | input | 1 | Crossing valid, sampled with the second transfer |
| link_lines_n | input | 384 | Twelve 32-line active-low links, link l at bits 32l+31:32l |
| out_cands | output | 84 | Four 21-bit winners, channel k at bits 21k+20:21k, channel 0 best |
| out_valid | output | 1 | Outputs hold a valid crossing result |

## Verification
A corrupted rank register shows as a duplicated, missing or out-of-order winner on the output channels. This appears at the very next crossing update, one crossing before the pipeline would otherwise flush it. A slipped half-crossing phase swaps the low and high halves of every link. That moves fields between slots and changes winners at once, so each directed scenario compares all four channels against a bench ranking computed from the candidate list. Zero-quality payloads, index ties across links and within a link, the unused top bit, and a phase held across an enable gap are each driven so that a mistake changes a visible channel value.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int unsigned LINKS_DEF = 12;
  localparam int unsigned LANE_DEF  = 32;
  localparam int unsigned SLOTS_DEF = 3;
  localparam int unsigned CAND_DEF  = 21;
  localparam int unsigned QUAL_DEF  = 6;
  localparam int unsigned OUTS_DEF  = 4;

  typedef enum logic {
    PH_LO = 1'b0,
    PH_HI = 1'b1
  } half_e;
endpackage

// File: rtl/cbs_link_capture.sv
module cbs_link_capture
  import cbs_pkg::*;
#(
  parameter int unsigned NLINK  = LINKS_DEF,
  parameter int unsigned LANE_W = LANE_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce,
  input  logic                      in_valid,
  input  logic [NLINK*LANE_W-1:0]   lines_n,
  output logic [NLINK*2*LANE_W-1:0] word_q,
  output logic                      vld_q,
  output logic                      xing_o
);
  localparam int unsigned BUS_W  = NLINK * LANE_W;
  localparam int unsigned WORD_W = 2 * LANE_W;

  half_e                    half_q, half_d;
  logic [BUS_W-1:0]         lo_q, lo_d;
  logic [NLINK*WORD_W-1:0]  word_d;
  logic                     vld_d;

  // second transfer of a crossing: the crossing-rate update point
  assign xing_o = ce && (half_q == PH_HI);

  always_comb begin
    half_d = half_q;
    lo_d   = lo_q;
    vld_d  = vld_q;
    if (ce) begin
      half_d = (half_q == PH_LO) ? PH_HI : PH_LO;
      if (half_q == PH_LO) lo_d = ~lines_n;
    end
    if (xing_o) vld_d = in_valid;
  end

  for (genvar l = 0; l < NLINK; l++) begin : g_link
    assign word_d[l*WORD_W +: WORD_W] = xing_o
      ? {~lines_n[l*LANE_W +: LANE_W], lo_q[l*LANE_W +: LANE_W]}
      : word_q[l*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= PH_LO;
      lo_q   <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      half_q <= half_d;
      lo_q   <= lo_d;
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  AST_LO_FROZEN_OFF_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (half_q == PH_HI || !ce) |=> $stable(lo_q)) else $error("low half moved off phase"); // R8
endmodule

// File: rtl/cbs_rank_stage.sv
module cbs_rank_stage
  import cbs_pkg::*;
#(
  parameter int unsigned NLINK  = LINKS_DEF,
  parameter int unsigned SLOTS  = SLOTS_DEF,
  parameter int unsigned LANE_W = LANE_DEF,
  parameter int unsigned CAND_W = CAND_DEF,
  parameter int unsigned QUAL_W = QUAL_DEF,
  parameter int unsigned NOUT   = OUTS_DEF
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          adv,
  input  logic [NLINK*2*LANE_W-1:0]                     word_i,
  input  logic                                          vld_i,
  output logic [NLINK*SLOTS*CAND_W-1:0]                 cand_q,
  output logic [NLINK*SLOTS*$clog2(NLINK*SLOTS)-1:0]    rank_q,
  output logic                                          vld_q
);
  localparam int unsigned NCAND  = NLINK * SLOTS;
  localparam int unsigned RANK_W = $clog2(NCAND);
  localparam int unsigned WORD_W = 2 * LANE_W;
  localparam int unsigned USED_W = SLOTS * CAND_W;
  localparam int unsigned SPARE  = WORD_W - USED_W;

  logic [CAND_W-1:0]       cand_w   [NCAND];
  logic [QUAL_W-1:0]       qual_w   [NCAND];
  logic [NCAND-1:0]        beat_row [NCAND];
  logic [NCAND*CAND_W-1:0] cand_d;
  logic [NCAND*RANK_W-1:0] rank_d;
  logic                    vld_d;
  logic [NLINK*SPARE-1:0]  unused_spare;

  for (genvar l = 0; l < NLINK; l++) begin : g_link
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign cand_w[l*SLOTS+s] = word_i[l*WORD_W + s*CAND_W +: CAND_W];
      assign qual_w[l*SLOTS+s] = cand_w[l*SLOTS+s][CAND_W-1 -: QUAL_W];
      assign cand_d[(l*SLOTS+s)*CAND_W +: CAND_W] = adv ? cand_w[l*SLOTS+s]
                                                         : cand_q[(l*SLOTS+s)*CAND_W +: CAND_W];
    end
    assign unused_spare[l*SPARE +: SPARE] = word_i[l*WORD_W + USED_W +: SPARE];
  end

  // beat_row[i][j]: candidate j outranks candidate i
  for (genvar i = 0; i < NCAND; i++) begin : g_rank
    always_comb begin
      for (int j = 0; j < NCAND; j++) begin
        beat_row[i][j] = (qual_w[j] > qual_w[i]) || ((qual_w[j] == qual_w[i]) && (j < i));
      end
    end
    assign rank_d[i*RANK_W +: RANK_W] = adv ? RANK_W'($countones(beat_row[i]))
                                            : rank_q[i*RANK_W +: RANK_W];
  end

  assign vld_d = adv ? vld_i : vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      vld_q  <= 1'b0;
      for (int i = 0; i < NCAND; i++) rank_q[i*RANK_W +: RANK_W] <= RANK_W'(i);
    end else begin
      cand_q <= cand_d;
      rank_q <= rank_d;
      vld_q  <= vld_d;
    end
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_chk
    logic [NCAND-1:0] hit;
    for (genvar i = 0; i < NCAND; i++) begin : g_hit
      assign hit[i] = (rank_q[i*RANK_W +: RANK_W] == RANK_W'(k));
    end
    AST_RANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(hit)) else $error("rank %0d not unique", k); // R5
  end
endmodule

// File: rtl/cbs_pick_stage.sv
module cbs_pick_stage
  import cbs_pkg::*;
#(
  parameter int unsigned NCAND  = LINKS_DEF * SLOTS_DEF,
  parameter int unsigned CAND_W = CAND_DEF,
  parameter int unsigned QUAL_W = QUAL_DEF,
  parameter int unsigned NOUT   = OUTS_DEF
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 adv,
  input  logic [NCAND*CAND_W-1:0]              cand_i,
  input  logic [NCAND*$clog2(NCAND)-1:0]       rank_i,
  input  logic                                 vld_i,
  output logic [NOUT*CAND_W-1:0]               out_q,
  output logic                                 vld_q
);
  localparam int unsigned RANK_W = $clog2(NCAND);

  logic [NOUT*CAND_W-1:0] pick_d;
  logic [CAND_W-1:0]      sel_c;
  logic                   vld_d;

  always_comb begin
    pick_d = out_q;
    sel_c  = '0;
    if (adv) begin
      for (int k = 0; k < NOUT; k++) begin
        sel_c = '0;
        for (int i = 0; i < NCAND; i++) begin
          if (rank_i[i*RANK_W +: RANK_W] == RANK_W'(k)) sel_c = cand_i[i*CAND_W +: CAND_W];
        end
        if (sel_c[CAND_W-1 -: QUAL_W] == '0) sel_c = '0;
        pick_d[k*CAND_W +: CAND_W] = sel_c;
      end
    end
  end

  assign vld_d = adv ? vld_i : vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      out_q <= pick_d;
      vld_q <= vld_d;
    end
  end

  for (genvar k = 1; k < NOUT; k++) begin : g_ord
    AST_ORDER_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
      out_q[(k-1)*CAND_W + CAND_W-1 -: QUAL_W] >= out_q[k*CAND_W + CAND_W-1 -: QUAL_W])
      else $error("channel %0d outranks channel %0d", k, k-1); // R4
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_emp
    AST_EMPTY_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q[k*CAND_W + CAND_W-1 -: QUAL_W] == '0) |-> (out_q[k*CAND_W +: CAND_W] == '0))
      else $error("empty channel %0d carries payload", k); // R6
  end
endmodule

// File: rtl/cand_best4_sorter.sv
module cand_best4_sorter
  import cbs_pkg::*;
#(
  parameter int unsigned NLINK  = LINKS_DEF,
  parameter int unsigned LANE_W = LANE_DEF,
  parameter int unsigned SLOTS  = SLOTS_DEF,
  parameter int unsigned CAND_W = CAND_DEF,
  parameter int unsigned QUAL_W = QUAL_DEF,
  parameter int unsigned NOUT   = OUTS_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce,
  input  logic                     in_valid,
  input  logic [NLINK*LANE_W-1:0]  link_lines_n,
  output logic [NOUT*CAND_W-1:0]   out_cands,
  output logic                     out_valid
);
  localparam int unsigned NCAND  = NLINK * SLOTS;
  localparam int unsigned RANK_W = $clog2(NCAND);

  logic [NLINK*2*LANE_W-1:0] word_s1;
  logic                      vld_s1;
  logic                      xing;
  logic [NCAND*CAND_W-1:0]   cand_s2;
  logic [NCAND*RANK_W-1:0]   rank_s2;
  logic                      vld_s2;

  cbs_link_capture #(.NLINK(NLINK), .LANE_W(LANE_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (ce),
    .in_valid (in_valid),
    .lines_n  (link_lines_n),
    .word_q   (word_s1),
    .vld_q    (vld_s1),
    .xing_o   (xing)
  );

  cbs_rank_stage #(.NLINK(NLINK), .SLOTS(SLOTS), .LANE_W(LANE_W), .CAND_W(CAND_W),
                   .QUAL_W(QUAL_W), .NOUT(NOUT)) u_rank (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (xing),
    .word_i (word_s1),
    .vld_i  (vld_s1),
    .cand_q (cand_s2),
    .rank_q (rank_s2),
    .vld_q  (vld_s2)
  );

  cbs_pick_stage #(.NCAND(NCAND), .CAND_W(CAND_W), .QUAL_W(QUAL_W), .NOUT(NOUT)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (xing),
    .cand_i (cand_s2),
    .rank_i (rank_s2),
    .vld_i  (vld_s2),
    .out_q  (out_cands),
    .vld_q  (out_valid)
  );

  AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(out_cands) && $stable(out_valid))) else $error("outputs moved while gated"); // R8

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(vld_s2)) else $error("valid without predecessor"); // R7
endmodule

// File: tb/cand_best4_sorter_tb.sv
`timescale 1ns/1ps
module cand_best4_sorter_tb;
  localparam int NL = 12, LW = 32, SL = 3, CW = 21, QW = 6, NO = 4, NC = NL*SL;

  logic clk = 1'b0;
  logic rst_n, ce, in_valid;
  logic [NL*LW-1:0] lines;
  logic [NO*CW-1:0] out_cands;
  logic out_valid;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [CW-1:0] bc [NC];
  logic [CW-1:0] ex [NO];
  logic [CW-1:0] exh [3][NO];
  logic [NL*LW-1:0] lo_v, hi_v;

  always #2.5 clk = ~clk;

  cand_best4_sorter u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .in_valid(in_valid),
    .link_lines_n(lines), .out_cands(out_cands), .out_valid(out_valid)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [NL*LW-1:0] l, input logic v, input logic e);
    @(negedge clk);
    lines = l; in_valid = v; ce = e;
    @(posedge clk);
    #1;
  endtask

  task automatic send(input logic v);
    step(lo_v, 1'b0, 1'b1);
    step(hi_v, v, 1'b1);
  endtask

  task automatic idle();
    step('1, 1'b0, 1'b1);
    step('1, 1'b0, 1'b1);
  endtask

  task automatic build(input logic b63);
    for (int l = 0; l < NL; l++) begin
      logic [63:0] w;
      w = {b63, bc[l*3+2], bc[l*3+1], bc[l*3]};
      lo_v[l*LW +: LW] = ~w[31:0];
      hi_v[l*LW +: LW] = ~w[63:32];
    end
  endtask

  task automatic clear_bc();
    for (int i = 0; i < NC; i++) bc[i] = '0;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < NC; i++) begin
      int q, p;
      q = ((i*37 + seed*11) ^ (i >> 1)) % 64;
      p = (i*seed*97 + 5 + i) & 32'h7fff;
      bc[i] = {q[5:0], p[14:0]};
    end
  endtask

  // ranking from the requirements: highest quality first, lower index on ties, zero is empty
  task automatic expect_best();
    bit used [NC];
    for (int i = 0; i < NC; i++) used[i] = 0;
    for (int k = 0; k < NO; k++) begin
      int best;
      best = -1;
      for (int i = 0; i < NC; i++) begin
        if (!used[i] && bc[i][CW-1 -: QW] != 0 &&
            (best < 0 || bc[i][CW-1 -: QW] > bc[best][CW-1 -: QW])) best = i;
      end
      if (best < 0) ex[k] = '0;
      else begin ex[k] = bc[best]; used[best] = 1; end
    end
  endtask

  task automatic chk_out(input string req);
    for (int k = 0; k < NO; k++) chk(req, out_cands[k*CW +: CW], ex[k]);
    chk(req, out_valid, 1'b1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ce = 1'b0; in_valid = 1'b0; lines = '1;
    repeat (3) @(posedge clk);
    #1;
    for (int k = 0; k < NO; k++) chk("R1 channel zero", out_cands[k*CW +: CW], '0);
    chk("R1 valid low", out_valid, 1'b0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_basic();
    fill(3); build(1'b0); expect_best();
    send(1'b1); idle(); idle();
    chk_out("R4 best four");
  endtask

  task automatic t_ties();
    clear_bc();
    for (int i = 0; i < NC; i++) bc[i] = {6'd9, 15'(i + 100)};
    bc[17] = {6'd40, 15'h1111};  // link 5 slot 2
    bc[21] = {6'd40, 15'h2222};  // link 7 slot 0
    bc[22] = {6'd40, 15'h3333};  // link 7 slot 1
    build(1'b0); expect_best();
    send(1'b1); idle(); idle();
    chk_out("R5 tie order");
    chk("R5 channel3 index0", out_cands[3*CW +: CW], {6'd9, 15'd100});
  endtask

  task automatic t_empty();
    clear_bc();
    bc[30] = {6'd5, 15'h0abc};
    bc[4]  = {6'd20, 15'h0123};
    bc[10] = {6'd0, 15'h7fff};
    build(1'b0); expect_best();
    send(1'b1); idle(); idle();
    chk_out("R6 empty channels");
    chk("R6 channel2 zero", out_cands[2*CW +: CW], '0);
    step('1, 1'b0, 1'b1); step('1, 1'b1, 1'b1); idle(); idle();
    for (int k = 0; k < NO; k++) chk("R2 idle lines give nothing", out_cands[k*CW +: CW], '0);
    chk("R2 valid", out_valid, 1'b1);
  endtask

  task automatic t_bit63();
    fill(5); build(1'b1); expect_best();
    send(1'b1); idle(); idle();
    chk_out("R3 layout and spare bit");
  endtask

  task automatic t_latency();
    fill(7); build(1'b0); expect_best();
    send(1'b1);
    idle();
    chk("R7 not yet valid", out_valid, 1'b0);
    idle();
    chk_out("R7 third update");
    idle();
    chk("R7 valid drops", out_valid, 1'b0);
  endtask

  task automatic t_stream();
    int seeds [3] = '{11, 13, 17};
    for (int c = 0; c < 3; c++) begin
      fill(seeds[c]); build(1'b0); expect_best();
      for (int k = 0; k < NO; k++) exh[c][k] = ex[k];
      send(1'b1);
    end
    for (int c = 0; c < 3; c++) begin
      if (c > 0) idle();
      for (int k = 0; k < NO; k++) ex[k] = exh[c][k];
      chk_out("R9 back to back");
    end
  endtask

  task automatic t_gate();
    logic [NO*CW-1:0] snap;
    logic snap_v;
    fill(19); build(1'b0); expect_best();
    step(lo_v, 1'b0, 1'b1);
    snap = out_cands; snap_v = out_valid;
    for (int r = 0; r < 6; r++) step({NL{32'h0f0f_0000 + 32'(r)}}, 1'b1, 1'b0);
    chk("R8 frozen channels", out_cands, snap);
    chk("R8 frozen valid", out_valid, snap_v);
    step(hi_v, 1'b1, 1'b1);
    idle(); idle();
    chk_out("R8 resumed crossing");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_ties();
    t_empty();
    t_bit63();
    t_latency();
    t_stream();
    t_gate();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule